// File: doc/BRIEF.md
# Gated Minterm Ripple Adder

This block is a ripple-carry adder in which every bit is a two-level sum of products over the eight input combinations of that bit. Each combination has its own product term, and the terms are indexed by reading the operand bit `a`, the operand bit `b` and the incoming carry as a 3-bit number. Three gating controls either switch individual product terms off or add one extra term. This lets the same slices act as an adder, an exclusive-or unit, an or unit or an and unit. No result multiplexer is used.

A subtract control inverts the `b` operand and forces the carry into bit 0. The result and the final carry are captured in an output register. The register loads when the enable input is high and keeps its value otherwise. A surrounding datapath sets the three controls from its opcode, and it keeps `c0` low for the logic functions.

Top module: `gated_ripple_alu`

## Requirements
- R1: While `rst_n` is low, `result` and `carry` are 0.
- R2: With f1=1, f2=1, f3=0 and sub=0, the registered `{carry, result}` equals a + b + c0 as a WIDTH+1 bit unsigned sum.
- R3: With f1=1, f2=0, f3=0, c0=0 and sub=0, `result` equals a XOR b and `carry` is 0.
- R4: With f1=1, f2=0, f3=1, c0=0 and sub=0, `result` equals a OR b and `carry` is 0.
- R5: With f1=0, f2=0, f3=1, c0=0 and sub=0, `result` equals a AND b and `carry` is 0.
- R6: With sub=1, f1=1, f2=1 and f3=0, `result` equals (a - b) mod 2^WIDTH, and `carry` is 1 exactly when a >= b as unsigned numbers. The value of c0 does not matter in this case.
- R7: For every setting of the controls, each bit i works as follows. Let bi be b XOR sub, let cin of bit 0 be c0 OR sub, and let cin of bit i+1 be the carry of bit i. Let row = {a_i, bi, cin}, with a_i as the most significant bit. The sum bit is 1 for rows 1 and 7, for rows 2 and 4 only when f1=1, and for row 6 only when f3=1. The carry is 1 for rows 3, 5 and 7, and for row 6 only when f2=1. `carry` is the carry out of the top bit.
- R8: With f2=0, c0=0 and sub=0, `carry` is 0 for every value of f1, f3, a and b.
- R9: While `en` is low, `result` and `carry` keep their values.
- R10: The outputs show the function of the inputs that were sampled at the rising edge where `en` was high. Until that edge, the outputs keep their earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| c0 | input | 1 | Carry into bit 0 |
| sub | input | 1 | Subtract: inverts b and forces the carry into bit 0 |
| f1 | input | 1 | Gate for the single-one sum terms (rows 2 and 4) |
| f2 | input | 1 | Gate for the carry-generate term (row 6) |
| f3 | input | 1 | Adds the row-6 term to the sum |
| result | output | WIDTH | Registered result |
| carry | output | 1 | Registered carry out of the top bit |

## Verification
The bench builds the block with WIDTH=4. At that width every pair of operands can be applied under each of the 16 combinations of f1, f2, f3 and c0, so every product-term gating is exercised with carries rippling through the whole chain. Subtraction is also swept over all 256 operand pairs, which covers both the borrow and the no-borrow edges (a=b, a=0, b=15). The output register's hold and one-cycle load behaviour are checked with directed sequences.

// File: rtl/gra_pkg.sv
package gra_pkg;

  // Row index of a bit's product term: {a, b, cin}, a is the MSB.
  localparam int unsigned ROWS = 8;

  // Rows whose product term feeds the sum output (1, 2, 4, 7).
  localparam logic [ROWS-1:0] SUM_ROWS   = 8'b1001_0110;
  // Rows whose product term feeds the carry output (3, 5, 6, 7).
  localparam logic [ROWS-1:0] CARRY_ROWS = 8'b1110_1000;

  // Row used by the carry-generate gate and the extra sum term.
  localparam int unsigned GEN_ROW = 6;

  typedef struct packed {
    logic f1;  // single-one sum terms
    logic f2;  // carry generate term
    logic f3;  // extra sum term on the generate row
  } gate_ctrl_t;

  // Per-row enable: rows 2 and 4 follow f1, row 6 follows f2.
  function automatic logic [ROWS-1:0] row_enable(input gate_ctrl_t g);
    logic [ROWS-1:0] m;
    m = '1;
    m[2] = g.f1;
    m[4] = g.f1;
    m[GEN_ROW] = g.f2;
    return m;
  endfunction

endpackage

// File: rtl/gra_operand_prep.sv
module gra_operand_prep #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             c0_in,
  input  logic             sub_in,
  output logic [WIDTH-1:0] b_eff,
  output logic             cin0
);

  // Subtract conditions b by exclusive-or and supplies the +1.
  always_comb begin
    b_eff = b_in ^ {WIDTH{sub_in}};
    cin0  = c0_in | sub_in;
  end

endmodule

// File: rtl/gra_minterm_bit.sv
module gra_minterm_bit
  import gra_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin,
  input  gate_ctrl_t ctrl,
  output logic       sum,
  output logic       cout
);

  logic [ROWS-1:0] hit;
  logic [ROWS-1:0] en_mask;

  // One product term per truth-table row.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [2:0] IDX = 3'(r);
    assign hit[r] = (a_i == IDX[2]) & (b_i == IDX[1]) & (cin == IDX[0]);
  end

  always_comb begin
    en_mask = row_enable(ctrl);
    sum  = (|(hit & en_mask & SUM_ROWS)) | (ctrl.f3 & hit[GEN_ROW]);
    cout = |(hit & en_mask & CARRY_ROWS);
  end

endmodule

// File: rtl/gra_ripple_chain.sv
module gra_ripple_chain
  import gra_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin0,
  input  gate_ctrl_t       ctrl,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] c;

  assign c[0] = cin0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    gra_minterm_bit u_bit (
      .a_i  (a[i]),
      .b_i  (b[i]),
      .cin  (c[i]),
      .ctrl (ctrl),
      .sum  (sum[i]),
      .cout (c[i+1])
    );
  end

  assign cout = c[WIDTH];

endmodule

// File: rtl/gated_ripple_alu.sv
module gated_ripple_alu
  import gra_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c0,
  input  logic             sub,
  input  logic             f1,
  input  logic             f2,
  input  logic             f3,
  output logic [WIDTH-1:0] result,
  output logic             carry
);

  gate_ctrl_t       ctrl;
  logic [WIDTH-1:0] b_eff;
  logic             cin0;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic [WIDTH-1:0] result_d, result_q;
  logic             carry_d, carry_q;

  assign ctrl = '{f1: f1, f2: f2, f3: f3};

  gra_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_in   (b),
    .c0_in  (c0),
    .sub_in (sub),
    .b_eff  (b_eff),
    .cin0   (cin0)
  );

  gra_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a    (a),
    .b    (b_eff),
    .cin0 (cin0),
    .ctrl (ctrl),
    .sum  (sum_w),
    .cout (cout_w)
  );

  // Next state with explicit load enable.
  always_comb begin
    result_d = result_q;
    carry_d  = carry_q;
    if (en) begin
      result_d = sum_w;
      carry_d  = cout_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      carry_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      carry_q  <= carry_d;
    end
  end

  assign result = result_q;
  assign carry  = carry_q;

endmodule

// File: rtl/gated_ripple_alu_chk.sv
module gated_ripple_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             c0,
  input logic             sub,
  input logic             f1,
  input logic             f2,
  input logic             f3,
  input logic [WIDTH-1:0] result,
  input logic             carry
);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (result == '0 && carry == 1'b0); // R1
    end
  end

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && f1 && f2 && !f3 && !sub) |=>
      ({carry, result} == ({1'b0, $past(a)} + {1'b0, $past(b)} + (WIDTH+1)'($past(c0))))); // R2

  AST_XOR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && f1 && !f2 && !f3 && !c0 && !sub) |=> (result == ($past(a) ^ $past(b)))); // R3

  AST_OR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && f1 && !f2 && f3 && !c0 && !sub) |=> (result == ($past(a) | $past(b)))); // R4

  AST_AND_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !f1 && !f2 && f3 && !c0 && !sub) |=> (result == ($past(a) & $past(b)))); // R5

  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sub && f1 && f2 && !f3) |=>
      (result == WIDTH'($past(a) - $past(b)) && carry == ($past(a) >= $past(b)))); // R6

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !f2 && !c0 && !sub) |=> (carry == 1'b0)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(result) && $stable(carry))); // R9

endmodule

bind gated_ripple_alu gated_ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .a      (a),
  .b      (b),
  .c0     (c0),
  .sub    (sub),
  .f1     (f1),
  .f2     (f2),
  .f3     (f3),
  .result (result),
  .carry  (carry)
);

// File: tb/gated_ripple_alu_bench.sv
module gated_ripple_alu_bench;

  localparam int unsigned W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         c0 = 1'b0;
  logic         sub = 1'b0;
  logic         f1 = 1'b0;
  logic         f2 = 1'b0;
  logic         f3 = 1'b0;
  logic [W-1:0] result;
  logic         carry;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_ripple_alu #(.WIDTH(W)) u_gated_ripple_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .c0(c0), .sub(sub),
    .f1(f1), .f2(f2), .f3(f3), .result(result), .carry(carry)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%0d b=%0d c0=%0b sub=%0b f=%0b%0b%0b actual=%0h expected=%0h",
               req, a, b, c0, sub, f1, f2, f3, act, exp);
    end
  endtask

  // Bit-level reference built from the row rules of R7.
  function automatic logic [W:0] row_model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                           input logic c0v, input logic sv,
                                           input logic g1, input logic g2, input logic g3);
    logic [W-1:0] s;
    logic cy;
    cy = c0v | sv;
    for (int i = 0; i < W; i++) begin
      int row;
      row = {av[i], bv[i] ^ sv, cy};
      s[i] = (row == 1) || (row == 7) || (g1 && (row == 2 || row == 4)) || (g3 && row == 6);
      cy   = (row == 3) || (row == 5) || (row == 7) || (g2 && row == 6);
    end
    return {cy, s};
  endfunction

  // Drive at the falling edge; outputs are compared one falling edge later.
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic c0v,
                       input logic sv, input logic g1, input logic g2, input logic g3);
    a = av; b = bv; c0 = c0v; sub = sv; f1 = g1; f2 = g2; f3 = g3; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    en = 1'b1; a = 4'hF; b = 4'hF; c0 = 1'b1; f1 = 1'b1; f2 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset", {carry, result}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 16; k++) begin
      logic g1, g2, g3, cz;
      {g1, g2, g3, cz} = 4'(k);
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          logic [W-1:0] av, bv;
          av = W'(x); bv = W'(y);
          apply(av, bv, cz, 1'b0, g1, g2, g3);
          chk("R7 row gating", {carry, result}, row_model(av, bv, cz, 1'b0, g1, g2, g3));
          if (g1 && g2 && !g3)
            chk("R2 add", {carry, result}, {1'b0, av} + {1'b0, bv} + (W+1)'(cz));
          if (!g2 && !cz) begin
            chk("R8 no carry", {4'b0, carry}, '0);
            if (g1 && !g3) chk("R3 xor", {1'b0, result}, {1'b0, av ^ bv});
            if (g1 && g3)  chk("R4 or",  {1'b0, result}, {1'b0, av | bv});
            if (!g1 && g3) chk("R5 and", {1'b0, result}, {1'b0, av & bv});
          end
        end
      end
    end
  endtask

  task automatic t_subtract;
    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y++) begin
        logic [W-1:0] av, bv;
        av = W'(x); bv = W'(y);
        apply(av, bv, 1'(x + y), 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R6 subtract", {carry, result}, {1'(x >= y), W'(x - y)});
      end
    end
  endtask

  task automatic t_hold;
    apply(4'd9, 4'd9, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);   // 18 -> carry 1, result 2
    en = 1'b0; a = 4'd1; b = 4'd2; f2 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold", {carry, result}, {1'b1, 4'd2});
  endtask

  task automatic t_latency;
    apply(4'd3, 4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);   // 7
    a = 4'd12; b = 4'd10; en = 1'b1;                    // new operands, no edge yet
    #1;
    chk("R10 before edge", {carry, result}, {1'b0, 4'd7});
    @(negedge clk);
    chk("R10 after edge", {carry, result}, {1'b1, 4'd6});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_subtract();
    t_hold();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule